// File: doc/BRIEF.md
# Sticky Window-Threshold Alarm Register

This block watches six monitored 12-bit quantities: gate voltage, sense voltage and temperature, for each of two channels. It checks each one against its own upper and lower limit. A new conversion arrives on `res_valid` together with a quantity index and the sample. The block captures it and checks it in the next cycle. Any limit that the sample crosses sets its own flag bit. That bit stays set until the host clears it.

The host sees the flags as a 16-bit word. A read strobe returns the current word in the same cycle and clears every flag at the next clock edge. A software clear input clears the flags in the same way without a read. `alarm_out` is high whenever any flag is latched. The limits are plain input ports. Every presented conversion is checked, whether or not anything else stores the sample.

The control is a two-state machine. ST_IDLE is the waiting state. The transition IDLE_TO_CHECK is taken on `res_valid` and captures the sample. ST_CHECK is the state in which the captured sample is compared and its flags are merged. The transition CHECK_TO_CHECK is taken when a further result arrives during a check. The transition CHECK_TO_IDLE is taken otherwise.

Top module: `alarm_window_monitor`

## Requirements
- R1: Bits 15 to 12 of `flag_word` are always 0.
- R2: Index encoding is: 0 = channel 1 gate, 1 = channel 1 sense, 2 = channel 1 temperature. Channel 1 flags occupy bits 5 to 0 as gate high (5), gate low (4), sense high (3), sense low (2), temperature high (1), temperature low (0).
- R3: Index 3 = channel 2 gate, 4 = channel 2 sense, 5 = channel 2 temperature. Their flags occupy bits 11 to 6 as gate high (11), gate low (10), sense high (9), sense low (8), temperature high (7), temperature low (6).
- R4: A high flag sets only when the sample is strictly greater than its upper limit. Equality sets nothing.
- R5: A low flag sets only when the sample is strictly less than its lower limit. Equality sets nothing.
- R6: A set flag stays set across later in-range samples until a read or a software clear.
- R7: While `rd_strobe` is high, `flag_word` shows the current flags. After that clock edge all flags are 0.
- R8: `sw_clear` clears all flags at the clock edge without a read.
- R9: A violation merged in the same cycle as a read is not shown in that read. It is still latched after the clear.
- R10: `alarm_out` is high exactly when any flag bit is set.
- R11: `busy` is high in the cycle after `res_valid` is accepted. The resulting flag appears after the second clock edge from the cycle in which `res_valid` was driven.
- R12: Indices 6 and 7 are ignored: they set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A new conversion result is presented |
| res_idx | input | 3 | Quantity index of the result |
| res_data | input | 12 | Conversion result |
| thr_hi | input | 72 | Upper limits, 12 bits per index, index 0 in bits 11:0 |
| thr_lo | input | 72 | Lower limits, 12 bits per index, index 0 in bits 11:0 |
| rd_strobe | input | 1 | Host read of the flag word; clears the flags |
| sw_clear | input | 1 | Software clear of all flags |
| flag_word | output | 16 | Latched alarm flags |
| alarm_out | output | 1 | OR of all latched flags |
| busy | output | 1 | A captured result is being checked |

## Verification
On every cycle, the assertions check the following:
- An accepted result makes `busy` rise one cycle later.
- With no clear pending, flags can only accumulate.
- A clear with no coincident violation empties the word.
- The alarm can only rise out of a check cycle.

Only the bench scenarios can show the following:
- The exact bit position for each index.
- The strictness of the comparisons at the limit values.
- The old-word-then-retained behaviour of a read that collides with a violation.
- That out-of-range indices leave the word unchanged.

// File: rtl/alarm_mon_pkg.sv
package alarm_mon_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_CHECK = 1'b1
    } mon_state_e;

    // Bit position of the upper-limit flag for a monitored index.
    // Channel c (index / qty) uses a group of 2*qty bits.
    // Within a group, quantity q takes the pair (high, low) counted from the top.
    function automatic int hi_bit_pos(input int idx, input int qty);
        hi_bit_pos = (idx / qty) * (2 * qty) + (2 * qty - 1) - 2 * (idx % qty);
    endfunction

endpackage

// File: rtl/alarm_ctrl_fsm.sv
module alarm_ctrl_fsm
    import alarm_mon_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [DATA_W-1:0] res_data,
    output logic              chk_en,
    output logic [IDX_W-1:0]  chk_idx,
    output logic [DATA_W-1:0] chk_data
);

    mon_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (res_valid) state_d = ST_CHECK;   // IDLE_TO_CHECK
            ST_CHECK: state_d = res_valid ? ST_CHECK        // CHECK_TO_CHECK
                                          : ST_IDLE;        // CHECK_TO_IDLE
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            chk_idx  <= '0;
            chk_data <= '0;
        end else begin
            state_q <= state_d;
            if (res_valid) begin
                chk_idx  <= res_idx;
                chk_data <= res_data;
            end
        end
    end

    always_comb begin
        chk_en = (state_q == ST_CHECK);
    end

    assert_busy_follows_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> chk_en);

endmodule

// File: rtl/alarm_window_cmp.sv
module alarm_window_cmp
    import alarm_mon_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int IDX_W   = 3,
    parameter int NUM_MON = 6,
    parameter int NUM_QTY = 3,
    parameter int FLAG_W  = 12
) (
    input  logic                      chk_en,
    input  logic [IDX_W-1:0]          chk_idx,
    input  logic [DATA_W-1:0]         chk_data,
    input  logic [NUM_MON*DATA_W-1:0] thr_hi,
    input  logic [NUM_MON*DATA_W-1:0] thr_lo,
    output logic [FLAG_W-1:0]         set_vec
);

    for (genvar m = 0; m < NUM_MON; m++) begin : g_lane
        localparam int HB = hi_bit_pos(m, NUM_QTY);
        logic sel;
        assign sel            = chk_en && (chk_idx == IDX_W'(m));
        assign set_vec[HB]    = sel && (chk_data > thr_hi[m*DATA_W +: DATA_W]);
        assign set_vec[HB-1]  = sel && (chk_data < thr_lo[m*DATA_W +: DATA_W]);
    end

endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg #(
    parameter int FLAG_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_any,
    input  logic              chk_en,
    input  logic [FLAG_W-1:0] set_vec,
    output logic [FLAG_W-1:0] flag_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (clr_any ? '0 : flag_q) | set_vec;
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_any |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_any && set_vec == '0) |=> (flag_q == '0));

    assert_alarm_from_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|flag_q) |-> $past(chk_en));

endmodule

// File: rtl/alarm_window_monitor.sv
module alarm_window_monitor
    import alarm_mon_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int NUM_CH  = 2,
    parameter int NUM_QTY = 3,
    parameter int WORD_W  = 16,
    parameter int IDX_W   = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              res_valid,
    input  logic [IDX_W-1:0]                  res_idx,
    input  logic [DATA_W-1:0]                 res_data,
    input  logic [NUM_CH*NUM_QTY*DATA_W-1:0]  thr_hi,
    input  logic [NUM_CH*NUM_QTY*DATA_W-1:0]  thr_lo,
    input  logic                              rd_strobe,
    input  logic                              sw_clear,
    output logic [WORD_W-1:0]                 flag_word,
    output logic                              alarm_out,
    output logic                              busy
);

    localparam int NUM_MON = NUM_CH * NUM_QTY;
    localparam int FLAG_W  = 2 * NUM_MON;
    localparam int PAD_W   = WORD_W - FLAG_W;

    logic              chk_en;
    logic [IDX_W-1:0]  chk_idx;
    logic [DATA_W-1:0] chk_data;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flag_q;

    alarm_ctrl_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_valid(res_valid),
        .res_idx  (res_idx),
        .res_data (res_data),
        .chk_en   (chk_en),
        .chk_idx  (chk_idx),
        .chk_data (chk_data)
    );

    alarm_window_cmp #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_MON(NUM_MON),
        .NUM_QTY(NUM_QTY), .FLAG_W(FLAG_W)
    ) u_cmp (
        .chk_en  (chk_en),
        .chk_idx (chk_idx),
        .chk_data(chk_data),
        .thr_hi  (thr_hi),
        .thr_lo  (thr_lo),
        .set_vec (set_vec)
    );

    alarm_flag_reg #(.FLAG_W(FLAG_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_any(rd_strobe | sw_clear),
        .chk_en (chk_en),
        .set_vec(set_vec),
        .flag_q (flag_q)
    );

    always_comb begin
        flag_word = {{PAD_W{1'b0}}, flag_q};
        alarm_out = |flag_q;
        busy      = chk_en;
    end

endmodule

// File: tb/test_alarm_window_monitor.sv
`timescale 1ns/1ps
module test_alarm_window_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [2:0]  res_idx = '0;
    logic [11:0] res_data = '0;
    logic [71:0] thr_hi, thr_lo;
    logic        rd_strobe = 1'b0;
    logic        sw_clear = 1'b0;
    logic [15:0] flag_word;
    logic        alarm_out, busy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    alarm_window_monitor i_alarm_window_monitor (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_idx(res_idx),
        .res_data(res_data), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .rd_strobe(rd_strobe), .sw_clear(sw_clear), .flag_word(flag_word),
        .alarm_out(alarm_out), .busy(busy)
    );

    function automatic logic [11:0] hi_of(int idx); return 12'(2000 + idx * 100); endfunction
    function automatic logic [11:0] lo_of(int idx); return 12'(500 + idx * 50); endfunction
    // Bit positions from R2/R3
    function automatic int hbit(int idx);
        int tbl [6] = '{5, 3, 1, 11, 9, 7};
        return tbl[idx];
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive at a falling edge; after two rising edges the flags are visible.
    task automatic present(int idx, int val);
        res_valid = 1'b1; res_idx = 3'(idx); res_data = 12'(val);
        @(negedge clk);
        res_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(output logic [15:0] w);
        rd_strobe = 1'b1;
        #0.1 w = flag_word;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset word", flag_word, 16'h0);
        chk("R10 reset alarm", alarm_out, 0);
        chk("R11 reset busy", busy, 0);
    endtask

    task automatic t_layout;
        logic [15:0] w;
        for (int i = 0; i < 6; i++) begin
            present(i, hi_of(i) + 1);
            chk(i < 3 ? "R2 high bit" : "R3 high bit", flag_word, 16'(1) << hbit(i));
            chk("R10 alarm set", alarm_out, 1);
            do_read(w);
            present(i, lo_of(i) - 1);
            chk(i < 3 ? "R2 low bit" : "R3 low bit", flag_word, 16'(1) << (hbit(i) - 1));
            do_read(w);
        end
        chk("R7 cleared after read", flag_word, 0);
        chk("R10 alarm clear", alarm_out, 0);
    endtask

    task automatic t_equal;
        present(4, hi_of(4));
        chk("R4 equal high", flag_word, 0);
        present(4, lo_of(4));
        chk("R5 equal low", flag_word, 0);
        present(0, 4095);
        chk("R4 max value", flag_word, 16'h0020);
        present(5, 0);
        chk("R5 zero value", flag_word, 16'h0060);
        sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
        chk("R8 sw clear", flag_word, 0);
    endtask

    task automatic t_sticky_read;
        logic [15:0] w;
        present(1, 3000);
        present(3, 100);
        present(1, 1500);
        present(3, 1500);
        chk("R6 sticky", flag_word, 16'h0408);
        chk("R1 upper zero", flag_word[15:12], 0);
        do_read(w);
        chk("R7 read value", w, 16'h0408);
        chk("R7 cleared", flag_word, 0);
    endtask

    task automatic t_busy;
        res_valid = 1'b1; res_idx = 3'd2; res_data = 12'd4000;
        @(negedge clk);
        res_valid = 1'b0;
        chk("R11 busy", busy, 1);
        chk("R11 not yet flagged", flag_word, 0);
        @(negedge clk);
        chk("R11 busy drop", busy, 0);
        chk("R11 flag visible", flag_word, 16'h0002);
        sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
    endtask

    task automatic t_collision;
        logic [15:0] w;
        present(0, 100);
        res_valid = 1'b1; res_idx = 3'd5; res_data = 12'd4000;
        @(negedge clk);
        res_valid = 1'b0;
        do_read(w);
        chk("R9 read shows old", w, 16'h0010);
        chk("R9 new retained", flag_word, 16'h0080);
        sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
    endtask

    task automatic t_bad_idx;
        present(6, 4095);
        present(7, 0);
        chk("R12 ignored index", flag_word, 0);
        chk("R12 no alarm", alarm_out, 0);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            thr_hi[i*12 +: 12] = hi_of(i);
            thr_lo[i*12 +: 12] = lo_of(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_equal();
        t_sticky_read();
        t_busy();
        t_collision();
        t_bad_idx();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog expired got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule